// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits between a set of level-sensitive interrupt request lines and a processor. Each source carries a programmable priority and an enable bit. Among the sources that are enabled, asserted and strictly above the level now being serviced, the controller selects one. It raises a single interrupt output whenever forwarding is globally enabled and such a source exists.

When the processor acknowledges, the controller latches the winning source index as the vector and marks that source's priority level as in service. It also turns off forwarding until software pulses the re-enable input. The in-service state is a bitmask with one bit per priority level, so it behaves as a stack. A higher-priority request can preempt a running handler and push a new level. Each end-of-interrupt pops the highest level and returns service to the handler it interrupted.

The request, acknowledge, end-of-interrupt and re-enable pins are plain control signals. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure. The processor reads the vector whenever it likes after an acknowledge.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset every source is disabled with priority 0, the in-service mask is empty, forwarding is off, `vec_o` is 0, and `irq_o` stays low whatever the request lines do.
- R2: `irq_o` is high exactly when forwarding is on and at least one source is enabled, has its request line high, and either nothing is in service or its priority is above `cur_lvl_o`. A disabled source never contributes.
- R3: Priorities are encoded 0 to 7, with 7 the highest. The winner is the qualifying source with the highest priority, and a tie goes to the lowest source index. An acknowledge taken while `irq_o` is high stores the winner's index in `vec_o`, which is visible from the next cycle.
- R4: A taken acknowledge sets the in-service bit of the winner's priority and turns forwarding off. `irq_o` then stays low until a re-enable pulse is taken.
- R5: While a level is in service, requests at that priority or below are masked. A request at a strictly higher priority is forwarded and, once acknowledged, nests above the current level.
- R6: An end-of-interrupt clears the highest set in-service bit. `cur_lvl_o` then returns to the level of the interrupted handler, and `busy_o` falls when the mask becomes empty.
- R7: An acknowledge while `irq_o` is low changes nothing. A request line that drops before it is acknowledged leaves no trace in the in-service state or the vector.
- R8: In a cycle where an acknowledge is taken, any end-of-interrupt or re-enable in the same cycle is ignored. If the acknowledge is not taken, those inputs act normally.
- R9: A cycle with `cfg_we` high writes `cfg_prio` and `cfg_en` into the source selected by `cfg_idx`, and the new values take effect from the next cycle.
- R10: `cur_lvl_o` is the index of the highest set in-service bit, or 0 when `busy_o` is low. `busy_o` is high when any in-service bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NSRC | Level-sensitive request lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | SRC_W | Source selected for the write |
| cfg_prio | input | LVL_W | Priority to write |
| cfg_en | input | 1 | Enable bit to write |
| ack_i | input | 1 | Processor acknowledge |
| eoi_i | input | 1 | End-of-interrupt pulse |
| reen_i | input | 1 | Global re-enable pulse |
| irq_o | output | 1 | Interrupt to the processor |
| vec_o | output | SRC_W | Latched vector (source index) |
| busy_o | output | 1 | Some level is in service |
| cur_lvl_o | output | LVL_W | Highest level in service |

## Verification
The bench builds the controller with its defaults of 8 sources and 8 levels. At that size every one of the 256 request patterns can be swept under three priority maps: all distinct, all tied, and reversed with half the sources disabled. Each sweep drives an acknowledge, a re-enable and an end-of-interrupt, so every winner and every masking relation is covered. With eight levels, the full nesting depth from level 0 up to level 7 and back down also fits in a short directed sequence.

// File: rtl/nic_pkg.sv
package nic_pkg;
  parameter int unsigned NIC_SRC_DEFAULT = 8;
  parameter int unsigned NIC_LVL_DEFAULT = 8;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/nic_cfg_regs.sv
module nic_cfg_regs #(
  parameter int unsigned NSRC  = 8,
  parameter int unsigned SRC_W = 3,
  parameter int unsigned LVL_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [SRC_W-1:0]           idx,
  input  logic [LVL_W-1:0]           prio_wr,
  input  logic                       en_wr,
  output logic [NSRC-1:0][LVL_W-1:0] prio_q,
  output logic [NSRC-1:0]            en_q
);
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prio_q[g] <= '0;
        en_q[g]   <= 1'b0;
      end else if (we && (idx == SRC_W'(g))) begin
        prio_q[g] <= prio_wr;
        en_q[g]   <= en_wr;
      end
    end
  end
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter #(
  parameter int unsigned NSRC  = 8,
  parameter int unsigned SRC_W = 3,
  parameter int unsigned LVL_W = 3
) (
  input  logic [NSRC-1:0]            req,
  input  logic [NSRC-1:0]            en,
  input  logic [NSRC-1:0][LVL_W-1:0] prio,
  input  logic                       busy,
  input  logic [LVL_W-1:0]           cur_lvl,
  output logic                       found,
  output logic [SRC_W-1:0]           win_idx,
  output logic [LVL_W-1:0]           win_lvl
);
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req[i] && en[i] && (!busy || (prio[i] > cur_lvl)) &&
          (!found || (prio[i] > win_lvl))) begin
        found   = 1'b1;
        win_idx = SRC_W'(i);
        win_lvl = prio[i];
      end
    end
  end
endmodule

// File: rtl/nic_inservice.sv
module nic_inservice #(
  parameter int unsigned NLVL  = 8,
  parameter int unsigned LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [LVL_W-1:0] push_lvl,
  input  logic             pop,
  output logic [NLVL-1:0]  mask,
  output logic             busy,
  output logic [LVL_W-1:0] cur_lvl
);
  always_comb begin
    cur_lvl = '0;
    for (int i = 0; i < NLVL; i++) begin
      if (mask[i]) cur_lvl = LVL_W'(i);
    end
  end

  assign busy = |mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask <= '0;
    end else if (push) begin
      mask[push_lvl] <= 1'b1;
    end else if (pop && busy) begin
      mask[cur_lvl] <= 1'b0;
    end
  end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nic_pkg::*;
#(
  parameter int unsigned NSRC  = NIC_SRC_DEFAULT,
  parameter int unsigned NLVL  = NIC_LVL_DEFAULT,
  parameter int unsigned SRC_W = idx_width(NSRC),
  parameter int unsigned LVL_W = idx_width(NLVL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  req_i,
  input  logic             cfg_we,
  input  logic [SRC_W-1:0] cfg_idx,
  input  logic [LVL_W-1:0] cfg_prio,
  input  logic             cfg_en,
  input  logic             ack_i,
  input  logic             eoi_i,
  input  logic             reen_i,
  output logic             irq_o,
  output logic [SRC_W-1:0] vec_o,
  output logic             busy_o,
  output logic [LVL_W-1:0] cur_lvl_o
);
  logic [NSRC-1:0][LVL_W-1:0] prio_q;
  logic [NSRC-1:0]            en_q;
  logic [NLVL-1:0]            is_mask;
  logic                       found;
  logic [SRC_W-1:0]           win_idx;
  logic [LVL_W-1:0]           win_lvl;
  logic                       fwd_en;
  logic                       take;

  nic_cfg_regs #(.NSRC(NSRC), .SRC_W(SRC_W), .LVL_W(LVL_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx),
    .prio_wr(cfg_prio), .en_wr(cfg_en), .prio_q(prio_q), .en_q(en_q)
  );

  nic_arbiter #(.NSRC(NSRC), .SRC_W(SRC_W), .LVL_W(LVL_W)) u_arb (
    .req(req_i), .en(en_q), .prio(prio_q), .busy(busy_o), .cur_lvl(cur_lvl_o),
    .found(found), .win_idx(win_idx), .win_lvl(win_lvl)
  );

  assign irq_o = fwd_en & found;
  assign take  = ack_i & irq_o;

  nic_inservice #(.NLVL(NLVL), .LVL_W(LVL_W)) u_isr (
    .clk(clk), .rst_n(rst_n), .push(take), .push_lvl(win_lvl),
    .pop(eoi_i), .mask(is_mask), .busy(busy_o), .cur_lvl(cur_lvl_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_en <= 1'b0;
      vec_o  <= '0;
    end else if (take) begin
      fwd_en <= 1'b0;
      vec_o  <= win_idx;
    end else if (reen_i) begin
      fwd_en <= 1'b1;
    end
  end
endmodule

// File: rtl/nic_checker.sv
module nic_checker #(
  parameter int unsigned NLVL  = 8,
  parameter int unsigned SRC_W = 3,
  parameter int unsigned LVL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack_i,
  input logic             eoi_i,
  input logic             irq_o,
  input logic [SRC_W-1:0] vec_o,
  input logic             busy_o,
  input logic [LVL_W-1:0] cur_lvl_o,
  input logic [NLVL-1:0]  mask
);
  assert_ack_masks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o) |=> !irq_o);

  assert_ack_pushes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o) |=> ($countones(mask) == $past($countones(mask)) + 1));

  assert_nest_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o && busy_o) |=> (cur_lvl_o > $past(cur_lvl_o)));

  assert_eoi_pops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_i && !(ack_i && irq_o) && busy_o) |=>
      ($countones(mask) + 1 == $past($countones(mask))));

  assert_eoi_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_i && !(ack_i && irq_o) && busy_o) |=>
      (!busy_o || (cur_lvl_o < $past(cur_lvl_o))));

  assert_ignored_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !irq_o && !eoi_i) |=> ($stable(mask) && $stable(vec_o)));

  assert_eoi_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o && eoi_i) |=> ($countones(mask) == $past($countones(mask)) + 1));
endmodule

bind nest_irq_ctrl nic_checker #(.NLVL(NLVL), .SRC_W(SRC_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_i(ack_i), .eoi_i(eoi_i), .irq_o(irq_o),
  .vec_o(vec_o), .busy_o(busy_o), .cur_lvl_o(cur_lvl_o), .mask(is_mask)
);

// File: tb/nest_irq_ctrl_test.sv
module nest_irq_ctrl_test;
  localparam int NS = 8;
  localparam int NL = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0] req_i = '0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_idx = '0;
  logic [2:0] cfg_prio = '0;
  logic cfg_en = 1'b0;
  logic ack_i = 1'b0, eoi_i = 1'b0, reen_i = 1'b0;
  logic irq_o, busy_o;
  logic [2:0] vec_o, cur_lvl_o;

  int ncmp = 0, nbad = 0;
  bit done = 0;

  int  mprio [NS];
  bit  men   [NS];
  bit  mmask [NL];
  bit  mgen;
  int  mvec;

  always #4 clk = ~clk;

  nest_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_prio(cfg_prio), .cfg_en(cfg_en), .ack_i(ack_i), .eoi_i(eoi_i),
    .reen_i(reen_i), .irq_o(irq_o), .vec_o(vec_o), .busy_o(busy_o),
    .cur_lvl_o(cur_lvl_o)
  );

  function automatic int top_lvl();
    int t = 0;
    for (int i = 0; i < NL; i++) if (mmask[i]) t = i;
    return t;
  endfunction

  function automatic bit any_busy();
    bit b = 0;
    for (int i = 0; i < NL; i++) b |= mmask[i];
    return b;
  endfunction

  function automatic void winner(output bit v, output int wi, output int wp);
    v = 0; wi = 0; wp = -1;
    for (int i = 0; i < NS; i++) begin
      if (req_i[i] && men[i] && (!any_busy() || mprio[i] > top_lvl()) && mprio[i] > wp) begin
        v = 1; wi = i; wp = mprio[i];
      end
    end
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    ncmp++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    bit v; int wi, wp;
    #1;
    winner(v, wi, wp);
    chk(tag, "irq_o R2", int'(irq_o), int'(v && mgen));
    chk(tag, "vec_o R3", int'(vec_o), mvec);
    chk(tag, "busy_o R10", int'(busy_o), int'(any_busy()));
    chk(tag, "cur_lvl_o R10", int'(cur_lvl_o), top_lvl());
  endtask

  task automatic tick(input bit a, input bit e, input bit r);
    bit v; int wi, wp;
    ack_i = a; eoi_i = e; reen_i = r;
    #1;
    winner(v, wi, wp);
    @(posedge clk);
    if (a && mgen && v) begin
      mvec = wi; mmask[wp] = 1; mgen = 0;
    end else begin
      if (e && any_busy()) mmask[top_lvl()] = 0;
      if (r) mgen = 1;
    end
    #1;
    ack_i = 0; eoi_i = 0; reen_i = 0;
  endtask

  task automatic wr_cfg(input int idx, input int p, input bit en);
    cfg_we = 1; cfg_idx = 3'(idx); cfg_prio = 3'(p); cfg_en = en;
    @(posedge clk);
    mprio[idx] = p; men[idx] = en;
    #1;
    cfg_we = 0;
  endtask

  task automatic set_req(input int pat);
    req_i = NS'(pat);
  endtask

  task automatic sweep(input string name);
    for (int pat = 0; pat < 256; pat++) begin
      set_req(pat);
      check_all({name, " R2 R9 select"});
      tick(1, 0, 0);
      check_all({name, " R3 R4 R7 ack"});
      tick(0, 0, 1);
      check_all({name, " R5 masked after reen"});
      tick(0, 1, 0);
      check_all({name, " R6 pop"});
    end
    set_req(0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    nbad++;
    $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NS; i++) begin mprio[i] = 0; men[i] = 0; end
    for (int i = 0; i < NL; i++) mmask[i] = 0;
    mgen = 0; mvec = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: reset state, requests ignored
    set_req(8'hFF);
    check_all("R1 reset");
    tick(1, 0, 0);
    check_all("R1 ack after reset");
    chk("R1", "irq_o low", int'(irq_o), 0);
    set_req(0);

    // Config A: distinct priorities, all enabled (R9)
    for (int i = 0; i < NS; i++) wr_cfg(i, (i * 5 + 3) % 8, 1);
    tick(0, 0, 1);
    sweep("cfgA");

    // Config B: all tied, lowest index wins (R3)
    for (int i = 0; i < NS; i++) wr_cfg(i, 4, 1);
    sweep("cfgB");

    // Config C: reversed, half disabled (R2 R9)
    for (int i = 0; i < NS; i++) wr_cfg(i, 7 - i, ((8'b1010_0110 >> i) & 1) != 0);
    sweep("cfgC");

    // Nesting: priority equals index
    for (int i = 0; i < NS; i++) wr_cfg(i, i, 1);
    set_req(8'b0000_0100);
    check_all("R5 base");
    tick(1, 0, 0);
    check_all("R4 pushed lvl2");
    tick(0, 0, 1);
    set_req(8'b0000_0110);
    check_all("R5 lower and equal masked");
    chk("R5", "irq_o masked", int'(irq_o), 0);
    set_req(8'b0010_0110);
    check_all("R5 higher preempts");
    tick(1, 0, 0);
    check_all("R5 nested lvl5");
    chk("R5", "cur_lvl_o", int'(cur_lvl_o), 5);
    chk("R3", "vec_o", int'(vec_o), 5);
    tick(0, 0, 1);
    set_req(8'b1010_0110);
    tick(1, 0, 0);
    check_all("R5 nested lvl7");
    tick(0, 1, 0);
    check_all("R6 back to 5");
    chk("R6", "cur_lvl_o", int'(cur_lvl_o), 5);
    tick(0, 1, 0);
    check_all("R6 back to 2");
    chk("R6", "cur_lvl_o", int'(cur_lvl_o), 2);
    tick(0, 1, 0);
    check_all("R6 empty");
    chk("R6", "busy_o", int'(busy_o), 0);

    // Full depth climb 0..7 and unwind
    set_req(0);
    tick(0, 0, 1);
    for (int i = 0; i < NS; i++) begin
      set_req(1 << i);
      tick(1, 0, 1);
      check_all("R5 climb");
      tick(0, 0, 1);
    end
    set_req(0);
    for (int i = 0; i < NL; i++) begin
      tick(0, 1, 0);
      check_all("R6 unwind");
    end

    // R7: withdrawn request and ignored ack
    set_req(8'b0000_1000);
    check_all("R7 raised");
    set_req(0);
    check_all("R7 withdrawn");
    tick(1, 0, 0);
    check_all("R7 ack ignored");
    chk("R7", "busy_o", int'(busy_o), 0);

    // R8: ack with eoi and reen in the same cycle
    set_req(8'b0000_0010);
    tick(1, 0, 0);
    tick(0, 0, 1);
    set_req(8'b0100_0010);
    tick(1, 1, 1);
    check_all("R8 ack wins over eoi and reen");
    chk("R8", "cur_lvl_o", int'(cur_lvl_o), 6);
    chk("R8", "irq_o off", int'(irq_o), 0);
    tick(0, 1, 1);
    check_all("R8 plain eoi and reen apply");
    chk("R8", "cur_lvl_o", int'(cur_lvl_o), 1);
    finish_run();
  end
endmodule